// File: doc/BRIEF.md
# Video Switch Control Register Target

This block is the two-wire serial control port of a three-input video switch. A host controller addresses it on the serial bus to program three 8-bit control bytes. The bytes select the active input port, enable the video output, steer the hot-plug outputs, set the input terminations and choose the analog drive settings. The block decodes a fixed 7-bit target address. The lowest address bit comes from a board strap, so two of these switches can share one bus. Register access goes through an internal pointer that advances by itself after each byte.

The block also watches the +5 V presence levels of the three input connectors. Any change on any of them, whether a plug or an unplug, sets a sticky event flag. That flag pulls an open-drain interrupt line low. The host reads the status byte, which shows the three live presence levels beside the flag, and acknowledges it. That acknowledged read clears the flag. All bus and presence inputs are brought into the system clock domain with two-flop synchronisers. START, STOP and clock edges are detected on the synchronised copies.

Top module: `swctl_i2c_regs`

## Requirements
- R1: After reset, register 0 reads 0x20, register 2 reads 0x12, register 1 reads 0xE0 when all presence pins are low, the interrupt pull-down is off and SDA is released.
- R2: The block acknowledges only the address byte whose upper seven bits are 1,0,1,0,1,0,strap, MSB first. The eighth bit selects the direction: 0 is a write, 1 is a read. Any other address gets no acknowledge, and the bytes that follow until the next START have no effect on the registers.
- R3: In a write, the byte after the address is the register pointer. The values 0, 1 and 2 select that register, and any other value selects register 0. The bytes after the pointer are data written at the pointer.
- R4: The pointer advances by one after every acknowledged data byte, in writes and in reads, and steps from register 2 back to register 0. A read byte that the master answers with NACK does not advance it.
- R5: A read returns bytes MSB first, starting at the current pointer, including a pointer left by an earlier transaction. A master ACK continues the read and a master NACK ends it.
- R6: Register 1 holds writable bits 7:5 (reset 1) and bit 0 (reset 0). Bits 4, 3 and 2 show the live synchronised levels of presence pins C, B and A (pwr_det_i[2], [1], [0]). Bit 1 shows the event flag. Writes to bits 4:1 have no effect.
- R7: A rising or falling level change on any presence pin sets the event flag. int_pull_o equals the flag, where 1 means the interrupt line is pulled low.
- R8: The flag clears only when register 1 was the byte just read and the master acknowledged it. A NACKed read of register 1 leaves the flag set.
- R9: If a presence change is seen in the same cycle as the clearing acknowledge, the flag stays set.
- R10: A repeated START without a STOP before it is accepted anywhere and restarts address decoding, so a non-matching address after it gets no acknowledge.
- R11: A STOP ends any transaction and releases SDA. Bytes clocked after it without a new START are not acknowledged and have no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_lsb_i | input | 1 | Strap giving the lowest target address bit |
| pwr_det_i | input | 3 | Connector presence levels, [0]=A, [1]=B, [2]=C |
| sda_pull_o | output | 1 | 1 pulls the SDA line low |
| int_pull_o | output | 1 | 1 pulls the interrupt line low (event flag) |
| cfg0_o | output | 8 | Register 0: [7:6] port select, [5] output enable, [4] hot-plug source, [3] hot-plug stage, [2:0] hot-plug levels |
| cfg1_o | output | 8 | Register 1 as read: [7:5] terminations, [4:2] presence C,B,A, [1] flag, [0] DDC mode |
| cfg2_o | output | 8 | Register 2: [7:6] swing, [5] pull-up, [4] squelch, [3:2] pre-emphasis, [1:0] equalisation |

## Verification
The properties assume that SDA changes only while SCL is low, except at START and STOP. They also assume that each SCL level lasts several system clocks longer than the two-flop synchroniser delay, so that every line edge is seen as exactly one detected event. The bench master drives the bus in quarter-bit steps of several clocks and changes SDA only in the low phase of SCL. It raises SDA only through its own release, the line being the wired-AND of both pull-downs. To reach the cycle-coincident edge-and-clear case, the bench toggles a presence pin on the same clock on which it raises SCL for the acknowledge bit. Both signals pass through synchronisers of equal depth.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

  localparam int NREG      = 3;
  localparam int PTR_W     = $clog2(NREG);
  localparam int NPORT     = 3;
  localparam int SYNC_DEPTH = 2;

  localparam logic [5:0] ADDR_UPPER = 6'b101010;

  localparam logic [7:0] REG0_RST   = 8'h20;
  localparam logic [7:0] REG2_RST   = 8'h12;
  localparam logic [2:0] TERM_RST   = 3'b111;
  localparam logic       DDCSEL_RST = 1'b0;

  localparam logic [PTR_W-1:0] STATUS_IDX = PTR_W'(1);

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_RX,
    BS_ACK_WAIT,
    BS_ACK_DRV,
    BS_TX,
    BS_TX_ACK,
    BS_TX_NEXT
  } bus_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;

endpackage

// File: rtl/swctl_sync.sv
module swctl_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/swctl_bus.sv
module swctl_bus
  import swctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       strap_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_pull_o,
  output logic       wr_ptr_stb_o,
  output logic       wr_data_stb_o,
  output logic [7:0] wr_byte_o,
  output logic       rd_ack_stb_o,
  output logic       start_det_o,
  output logic       stop_det_o
);

  bus_state_e state_q, state_n;
  byte_kind_e kind_q, kind_n;
  logic [2:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic       rw_q, rw_n;
  logic       scl_d, sda_d;

  logic scl_rise, scl_fall, start_c, stop_c;
  logic [7:0] rx_byte;

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign rx_byte  = {sh_q[6:0], sda_s};

  always_comb begin
    state_n       = state_q;
    kind_n        = kind_q;
    cnt_n         = cnt_q;
    sh_n          = sh_q;
    rw_n          = rw_q;
    wr_ptr_stb_o  = 1'b0;
    wr_data_stb_o = 1'b0;
    rd_ack_stb_o  = 1'b0;
    if (start_c) begin
      state_n = BS_RX;
      kind_n  = BK_ADDR;
      cnt_n   = '0;
    end else if (stop_c) begin
      state_n = BS_IDLE;
    end else begin
      unique case (state_q)
        BS_IDLE: ;
        BS_RX: begin
          if (scl_rise) begin
            sh_n  = rx_byte;
            cnt_n = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              unique case (kind_q)
                BK_ADDR: begin
                  if (rx_byte[7:1] == {ADDR_UPPER, strap_i}) begin
                    rw_n    = rx_byte[0];
                    state_n = BS_ACK_WAIT;
                  end else begin
                    state_n = BS_IDLE;
                  end
                end
                BK_PTR: begin
                  wr_ptr_stb_o = 1'b1;
                  state_n      = BS_ACK_WAIT;
                end
                default: begin
                  wr_data_stb_o = 1'b1;
                  state_n       = BS_ACK_WAIT;
                end
              endcase
            end
          end
        end
        BS_ACK_WAIT: begin
          if (scl_fall) state_n = BS_ACK_DRV;
        end
        BS_ACK_DRV: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (kind_q == BK_ADDR && rw_q) begin
              state_n = BS_TX;
              sh_n    = rd_data_i;
            end else begin
              state_n = BS_RX;
              kind_n  = (kind_q == BK_ADDR) ? BK_PTR : BK_DATA;
            end
          end
        end
        BS_TX: begin
          if (scl_fall) begin
            cnt_n = cnt_q + 3'd1;
            if (cnt_q == 3'd7) state_n = BS_TX_ACK;
            else               sh_n    = {sh_q[6:0], 1'b0};
          end
        end
        BS_TX_ACK: begin
          if (scl_rise) begin
            if (!sda_s) begin
              rd_ack_stb_o = 1'b1;
              state_n      = BS_TX_NEXT;
            end else begin
              state_n = BS_IDLE;
            end
          end
        end
        BS_TX_NEXT: begin
          if (scl_fall) begin
            sh_n    = rd_data_i;
            cnt_n   = '0;
            state_n = BS_TX;
          end
        end
        default: state_n = BS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
    end else begin
      state_q <= state_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      rw_q    <= rw_n;
      scl_d   <= scl_s;
      sda_d   <= sda_s;
    end
  end

  assign sda_pull_o  = (state_q == BS_ACK_DRV) | ((state_q == BS_TX) & ~sh_q[7]);
  assign wr_byte_o   = rx_byte;
  assign start_det_o = start_c;
  assign stop_det_o  = stop_c;

endmodule

// File: rtl/swctl_regs.sv
module swctl_regs
  import swctl_pkg::*;
#(
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ptr_stb_i,
  input  logic             wr_data_stb_i,
  input  logic [7:0]       wr_byte_i,
  input  logic             rd_ack_stb_i,
  input  logic [NPORT-1:0] pwr_s,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       cfg0_o,
  output logic [7:0]       cfg1_o,
  output logic [7:0]       cfg2_o,
  output logic             flag_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             pwr_edge_o
);

  localparam int ARM_MAX = STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_MAX + 1);

  logic [7:0]       r0_q, r0_n, r2_q, r2_n;
  logic [2:0]       term_q, term_n;
  logic             ddc_q, ddc_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             flag_q, flag_n;
  logic [NPORT-1:0] pwr_d;
  logic [ARM_W-1:0] arm_q, arm_n;
  logic             armed;
  logic [7:0]       view [NREG];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NREG - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign armed      = (arm_q == ARM_W'(ARM_MAX));
  assign pwr_edge_o = armed & (|(pwr_s ^ pwr_d));

  assign view[0] = r0_q;
  assign view[1] = {term_q, pwr_s, flag_q, ddc_q};
  assign view[2] = r2_q;

  always_comb begin
    r0_n   = r0_q;
    r2_n   = r2_q;
    term_n = term_q;
    ddc_n  = ddc_q;
    ptr_n  = ptr_q;
    arm_n  = armed ? arm_q : arm_q + ARM_W'(1);
    if (wr_ptr_stb_i) begin
      ptr_n = (wr_byte_i < 8'(NREG)) ? wr_byte_i[PTR_W-1:0] : '0;
    end else if (wr_data_stb_i) begin
      unique case (ptr_q)
        PTR_W'(0): r0_n = wr_byte_i;
        PTR_W'(1): begin
          term_n = wr_byte_i[7:5];
          ddc_n  = wr_byte_i[0];
        end
        default:   r2_n = wr_byte_i;
      endcase
      ptr_n = ptr_inc(ptr_q);
    end else if (rd_ack_stb_i) begin
      ptr_n = ptr_inc(ptr_q);
    end
    flag_n = pwr_edge_o | (flag_q & ~(rd_ack_stb_i & (ptr_q == STATUS_IDX)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q   <= REG0_RST;
      r2_q   <= REG2_RST;
      term_q <= TERM_RST;
      ddc_q  <= DDCSEL_RST;
      ptr_q  <= '0;
      flag_q <= 1'b0;
      pwr_d  <= '0;
      arm_q  <= '0;
    end else begin
      r0_q   <= r0_n;
      r2_q   <= r2_n;
      term_q <= term_n;
      ddc_q  <= ddc_n;
      ptr_q  <= ptr_n;
      flag_q <= flag_n;
      pwr_d  <= pwr_s;
      arm_q  <= arm_n;
    end
  end

  always_comb begin
    rd_data_o = view[0];
    for (int i = 1; i < NREG; i++) begin
      if (ptr_q == PTR_W'(i)) rd_data_o = view[i];
    end
  end

  assign cfg0_o = view[0];
  assign cfg1_o = view[1];
  assign cfg2_o = view[2];
  assign flag_o = flag_q;
  assign ptr_o  = ptr_q;

endmodule

// File: rtl/swctl_i2c_regs.sv
module swctl_i2c_regs
  import swctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_lsb_i,
  input  logic [2:0] pwr_det_i,
  output logic       sda_pull_o,
  output logic       int_pull_o,
  output logic [7:0] cfg0_o,
  output logic [7:0] cfg1_o,
  output logic [7:0] cfg2_o
);

  logic [1:0]       bus_s;
  logic [NPORT-1:0] pwr_s;
  logic [7:0]       rd_data, wr_byte;
  logic             wr_ptr_stb, wr_data_stb, rd_ack_stb;
  logic             start_det, stop_det, pwr_edge, flag;
  logic [PTR_W-1:0] ptr;

  swctl_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  swctl_sync #(.WIDTH(NPORT), .STAGES(SYNC_DEPTH)) u_pwr_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pwr_det_i), .q_o(pwr_s)
  );

  swctl_bus u_bus (
    .clk(clk), .rst_n(rst_n),
    .scl_s(bus_s[1]), .sda_s(bus_s[0]), .strap_i(addr_lsb_i),
    .rd_data_i(rd_data), .sda_pull_o(sda_pull_o),
    .wr_ptr_stb_o(wr_ptr_stb), .wr_data_stb_o(wr_data_stb),
    .wr_byte_o(wr_byte), .rd_ack_stb_o(rd_ack_stb),
    .start_det_o(start_det), .stop_det_o(stop_det)
  );

  swctl_regs #(.STAGES(SYNC_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ptr_stb_i(wr_ptr_stb), .wr_data_stb_i(wr_data_stb),
    .wr_byte_i(wr_byte), .rd_ack_stb_i(rd_ack_stb), .pwr_s(pwr_s),
    .rd_data_o(rd_data), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .cfg2_o(cfg2_o),
    .flag_o(flag), .ptr_o(ptr), .pwr_edge_o(pwr_edge)
  );

  assign int_pull_o = flag;

endmodule

// File: rtl/swctl_chk.sv
module swctl_chk
  import swctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sda_pull_o,
  input logic             int_pull_o,
  input logic             pwr_edge,
  input logic             rd_ack_stb,
  input logic             wr_ptr_stb,
  input logic [7:0]       wr_byte,
  input logic [PTR_W-1:0] ptr,
  input logic             start_det,
  input logic             stop_det
);

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_edge |=> int_pull_o);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_pull_o) |-> ($past(rd_ack_stb) && $past(ptr) == STATUS_IDX));

  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_edge && rd_ack_stb) |=> int_pull_o);

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PTR_W'(NREG));

  assert_ptr_oob_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_stb && wr_byte >= 8'(NREG)) |=> ptr == '0);

  assert_restart_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_o);

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);

endmodule

bind swctl_i2c_regs swctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .int_pull_o(int_pull_o),
  .pwr_edge(pwr_edge), .rd_ack_stb(rd_ack_stb), .wr_ptr_stb(wr_ptr_stb),
  .wr_byte(wr_byte), .ptr(ptr), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/tb_swctl_i2c_regs.sv
module tb_swctl_i2c_regs;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;
  localparam int NVEC       = 6;
  // {pointer, write data, expected readback}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd0, 8'hC5, 8'hC5}, {8'd0, 8'h00, 8'h00}, {8'd1, 8'hFF, 8'hE1},
    {8'd1, 8'h1E, 8'h00}, {8'd2, 8'hA5, 8'hA5}, {8'd2, 8'h5A, 8'h5A}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_pull = 1'b0, strap = 1'b1;
  logic [2:0] pwr = 3'b000;
  logic sda_line, sda_pull, int_pull;
  logic [7:0] cfg0, cfg1, cfg2;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = ~(m_pull | sda_pull);

  swctl_i2c_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .addr_lsb_i(strap),
    .pwr_det_i(pwr), .sda_pull_o(sda_pull), .int_pull_o(int_pull),
    .cfg0_o(cfg0), .cfg1_o(cfg1), .cfg2_o(cfg2)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_pull = 1'b0; scl = 1'b1; wq();
    m_pull = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_restart();
    m_pull = 1'b0; wq();
    scl = 1'b1; wq();
    m_pull = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_pull = 1'b1; wq();
    scl = 1'b1; wq();
    m_pull = 1'b0; wq();
  endtask

  task automatic wr_bit(input logic b, input bit tgl = 0);
    m_pull = ~b; wq();
    scl = 1'b1;
    if (tgl) pwr[0] = ~pwr[0];
    wq(2);
    scl = 1'b0; wq();
  endtask

  task automatic rd_bit(output logic b);
    m_pull = 1'b0; wq();
    scl = 1'b1; wq();
    b = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    rd_bit(a);
    acked = ~a;
  endtask

  task automatic rd_byte(input bit nack, input bit tgl, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rd_bit(d[i]);
    wr_bit(nack, tgl);
  endtask

  function automatic logic [7:0] adr(input logic rw);
    return {6'b101010, strap, rw};
  endfunction

  task automatic reg_write(input logic [7:0] p, input logic [7:0] d);
    bit a;
    i2c_start(); wr_byte(adr(0), a); wr_byte(p, a); wr_byte(d, a); i2c_stop();
  endtask

  // pointer write, repeated START, one byte read with NACK
  task automatic reg_read(input logic [7:0] p, output logic [7:0] d);
    bit a;
    i2c_start(); wr_byte(adr(0), a); wr_byte(p, a);
    i2c_restart(); wr_byte(adr(1), a); rd_byte(1, 0, d); i2c_stop();
  endtask

  // acknowledged read of register 1 followed by NACK of register 2
  task automatic status_clear(input bit tgl, output logic [7:0] d);
    bit a; logic [7:0] dummy;
    i2c_start(); wr_byte(adr(0), a); wr_byte(8'd1, a);
    i2c_restart(); wr_byte(adr(1), a); rd_byte(0, tgl, d); rd_byte(1, 0, dummy);
    i2c_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d;
    bit a;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R1 reset state
    chk("R1 cfg0", cfg0, 8'h20);
    chk("R1 cfg1", cfg1, 8'hE0);
    chk("R1 cfg2", cfg2, 8'h12);
    chk("R1 int_pull", {7'd0, int_pull}, 8'h00);
    chk("R1 sda_pull", {7'd0, sda_pull}, 8'h00);

    // table: write then read back via repeated START (R3 R5 R6 R10)
    for (int i = 0; i < NVEC; i++) begin
      reg_write(VEC[i][23:16], VEC[i][15:8]);
      reg_read(VEC[i][23:16], d);
      chk($sformatf("R5 readback vec%0d", i), d, VEC[i][7:0]);
    end
    chk("R6 cfg1 ro bits ignore writes", cfg1, 8'h00);

    // R2 wrong address is ignored
    i2c_start(); wr_byte({6'b101010, 1'b0, 1'b0}, a);
    chk("R2 wrong address nack", {7'd0, a}, 8'h00);
    wr_byte(8'h00, a); wr_byte(8'hEE, a); i2c_stop();
    chk("R2 no write on mismatch", cfg0, 8'h00);
    strap = 1'b0;
    reg_write(8'd0, 8'h3C);
    chk("R2 strap 0 address", cfg0, 8'h3C);

    // R4 burst write wraps 2 -> 0 -> 1
    i2c_start(); wr_byte(adr(0), a); wr_byte(8'd2, a);
    wr_byte(8'h81, a); wr_byte(8'h42, a); wr_byte(8'h21, a); i2c_stop();
    chk("R4 wrap reg2", cfg2, 8'h81);
    chk("R4 wrap reg0", cfg0, 8'h42);
    chk("R4 wrap reg1", cfg1, 8'h21);

    // R5 read from last pointer (2), ACK ACK NACK
    i2c_start(); wr_byte(adr(1), a);
    rd_byte(0, 0, d); chk("R5 cont read reg2", d, 8'h81);
    rd_byte(0, 0, d); chk("R5 cont read reg0", d, 8'h42);
    rd_byte(1, 0, d); chk("R5 cont read reg1", d, 8'h21);
    i2c_stop();
    // R4 NACKed byte did not advance pointer
    i2c_start(); wr_byte(adr(1), a); rd_byte(1, 0, d); i2c_stop();
    chk("R4 nack keeps pointer", d, 8'h21);

    // R3 out-of-range pointer selects register 0
    reg_write(8'h07, 8'h99);
    chk("R3 pointer 7 -> reg0", cfg0, 8'h99);
    chk("R3 reg2 untouched", cfg2, 8'h81);

    // R7 rising edge sets flag
    pwr = 3'b001; repeat (10) @(negedge clk);
    chk("R7 rise sets flag", {7'd0, int_pull}, 8'h01);
    chk("R6 live pin + flag", cfg1, 8'h27);
    // R8 NACKed read does not clear
    reg_read(8'd1, d);
    chk("R8 status value", d, 8'h27);
    chk("R8 nack keeps flag", {7'd0, int_pull}, 8'h01);
    status_clear(0, d);
    chk("R8 acked status value", d, 8'h27);
    chk("R8 ack clears flag", {7'd0, int_pull}, 8'h00);

    // R7 falling edge sets flag
    pwr = 3'b000; repeat (10) @(negedge clk);
    chk("R7 fall sets flag", {7'd0, int_pull}, 8'h01);
    status_clear(0, d);
    chk("R7 fall status", d, 8'h23);
    chk("R8 cleared again", {7'd0, int_pull}, 8'h00);

    // R9 edge coincident with clearing ACK
    pwr = 3'b010; repeat (10) @(negedge clk);
    status_clear(1, d);
    chk("R9 captured status", d, 8'h2B);
    chk("R9 flag survives", {7'd0, int_pull}, 8'h01);
    status_clear(0, d);
    chk("R9 later status", d, 8'h2F);
    chk("R9 later clear", {7'd0, int_pull}, 8'h00);

    // R10 repeated START restarts address decode
    i2c_start(); wr_byte(adr(0), a); wr_byte(8'd0, a); wr_byte(8'h11, a);
    i2c_restart(); wr_byte({6'b101010, ~strap, 1'b0}, a);
    chk("R10 restart mismatch nack", {7'd0, a}, 8'h00);
    wr_byte(8'h77, a); i2c_stop();
    chk("R10 only pre-restart write", cfg0, 8'h11);

    // R11 bytes after STOP without START are ignored
    wr_byte(8'hFF, a);
    chk("R11 no ack after stop", {7'd0, a}, 8'h00);
    chk("R11 sda released", {7'd0, sda_pull}, 8'h00);
    chk("R11 reg2 untouched", cfg2, 8'h81);
    m_pull = 1'b0; scl = 1'b1; wq(2);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule